// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes one incoming frame at a time as a byte stream and stores it in memory buffers. Each buffer is described by a four-word descriptor, and the descriptors are chained into a ring. For every frame the engine walks the ring from its current pointer until it finds a descriptor that it owns and whose buffer is large enough. It copies frame bytes into that buffer, then writes the descriptor's status word back. The write-back hands the descriptor to software and records the first and last flags and a length. If bytes remain, it looks for the next usable descriptor and repeats. It pulses set strobes for a receive-done interrupt bit and a buffer-unavailable interrupt bit, and a clear strobe for the receive-DMA-start control bit.

The surrounding register block loads the ring head and provides the receive enable. The frame length arrives as a sideband with the first byte. The memory side is a single request/acknowledge port. It carries byte writes with a one-hot lane strobe, word reads, and word writes.

Descriptor layout, as byte offsets from the descriptor address: +0 status word, +4 control word (bits [10:0] buffer size, bit 31 interrupt suppress), +8 buffer address, +12 next-descriptor address.

Top module: `rx_ring_scatter`

## Requirements
- R1: While `rxEnable` is low and no frame is in progress, `inReady` and `memReq` stay low and a waiting frame is not started.
- R2: A descriptor is usable only when status bit 31 is 1 and the buffer size in control bits [10:0] is at least 64. Any other descriptor is skipped.
- R3: The search begins at the current pointer, reads the four descriptor words at +0, +4, +8 and +12, and follows the next address. It fails when the address is zero, or when an unusable descriptor's next address equals the address the search began at.
- R4: If no usable descriptor exists when a frame starts, `bufUnavailSet` pulses once. Every byte of the frame is accepted and discarded, and the current pointer returns to the ring head.
- R5: The write-back is a single word write to +0. It clears bit 31, replaces bits [29:16] with the length, sets bit 9 on the frame's first descriptor, sets bit 8 on its last descriptor, and keeps every other bit.
- R6: When the buffer size is below both the remaining byte count and the remaining byte count plus 4, the engine writes exactly buffer-size bytes. The length field then holds the buffer size and bit 8 stays clear.
- R7: When the buffer size is at least the remaining byte count plus 4, all remaining bytes are stored and bit 8 is set. The length field holds the larger of the remaining count and 64, plus 4.
- R8: When the buffer size is at least the remaining byte count but below that count plus 4, all remaining bytes are stored and the frame ends. The length field holds the buffer size and bit 8 stays clear.
- R9: `rxDoneSet` pulses once for each written-back descriptor whose control bit 31 is 0, and not at all for one whose bit 31 is 1.
- R10: If bytes remain after a descriptor is written back and no usable descriptor follows, `bufUnavailSet` pulses. The pointer returns to the ring head and the remaining bytes are accepted and discarded.
- R11: Each started frame ends with exactly one `dmaStartClr` pulse. After a frame fully stored, the current pointer holds the next address of the last descriptor filled.
- R12: `inReady` is never high while a memory request is pending. Byte k of a descriptor's share is written to buffer address + k, with the one-hot strobe of that lane and the byte copied to every lane.
- R13: Once `memReq` is raised it stays high, with the address and write flag unchanged, until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable; frames are not started while low |
| ringLoad | input | 1 | Loads ring head and current pointer from `ringAddr` |
| ringAddr | input | 32 | Ring head address |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Stream byte accepted at the edge when both are high |
| inData | input | 8 | Stream byte |
| inLen | input | LEN_W | Frame length in bytes (at least 1), valid with the first byte |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = word read |
| memAddr | output | 32 | Byte address |
| memStrb | output | 4 | Byte lanes written |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completed this cycle |
| memRdata | input | 32 | Read data, valid with `memAck` |
| rxDoneSet | output | 1 | Pulse: set receive-done status |
| bufUnavailSet | output | 1 | Pulse: set buffer-unavailable status |
| dmaStartClr | output | 1 | Pulse: clear receive-DMA-start control bit |
| curDesc | output | 32 | Current descriptor pointer |

## Verification
The bench uses the default parameters: minimum buffer 64, four trailer bytes, 14-bit lengths and 11-bit buffer sizes. With a 64-byte minimum, frames of 5 to 30 bytes exercise the padded length, and a 63-byte buffer is the first size rejected. With 100-byte buffers, frame lengths of 96, 97 and 150 bytes land on each side of the four-byte margin. Small rings of one to three descriptors bring in wrap-around, a zero next address, a zero head and a mid-frame failure in a few hundred cycles.

// File: rtl/rx_ring_scatter_pkg.sv
package rx_ring_scatter_pkg;

  localparam int WORD_W    = 32;
  localparam int OWN_BIT   = 31;
  localparam int SUP_BIT   = 31;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int LENF_LSB  = 16;
  localparam int LENF_W    = 14;
  localparam logic [WORD_W-1:0] OWN_MASK  = 32'h1 << OWN_BIT;
  localparam logic [WORD_W-1:0] LENF_MASK = ((32'h1 << LENF_W) - 32'h1) << LENF_LSB;

  typedef enum logic [1:0] {OP_RD, OP_BYTE, OP_STAT} memOp_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SCHK, ST_RD, ST_EVAL, ST_DATA, ST_WRB, ST_STAT, ST_FAIL, ST_DROP
  } rxsState_e;

  typedef struct packed {
    logic   ldFrame;
    logic   capWord;
    logic   followNext;
    logic   setupFill;
    logic   takeByte;
    logic   byteDone;
    logic   descDone;
    logic   endOk;
    logic   fail;
    logic   dropByte;
    memOp_e memOp;
  } rxsStrobe_t;

  typedef struct packed {
    logic addrZero;
    logic owned;
    logic nextIsStart;
    logic lastWord;
    logic lastByte;
    logic frameComplete;
    logic intSuppress;
    logic oneLeft;
  } rxsFlag_t;

endpackage

// File: rtl/rx_ring_scatter_ctrl.sv
module rx_ring_scatter_ctrl
  import rx_ring_scatter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       inValid,
  input  logic       memAck,
  input  rxsFlag_t   flags,
  output rxsStrobe_t stb,
  output logic       memReq,
  output logic       inReady,
  output logic       rxDoneSet,
  output logic       bufUnavailSet,
  output logic       dmaStartClr,
  output logic       frameActive
);

  rxsState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    stb           = '0;
    stb.memOp     = OP_RD;
    memReq        = 1'b0;
    inReady       = 1'b0;
    rxDoneSet     = 1'b0;
    bufUnavailSet = 1'b0;
    dmaStartClr   = 1'b0;
    unique case (state)
      ST_IDLE: if (rxEnable && inValid) begin
        stb.ldFrame = 1'b1;
        stateNxt    = ST_SCHK;
      end
      ST_SCHK: stateNxt = flags.addrZero ? ST_FAIL : ST_RD;
      ST_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.capWord = 1'b1;
          if (flags.lastWord) stateNxt = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (flags.owned) begin
          stb.setupFill = 1'b1;
          stateNxt      = ST_DATA;
        end else if (flags.nextIsStart) begin
          stateNxt = ST_FAIL;
        end else begin
          stb.followNext = 1'b1;
          stateNxt       = ST_SCHK;
        end
      end
      ST_DATA: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeByte = 1'b1;
          stateNxt     = ST_WRB;
        end
      end
      ST_WRB: begin
        memReq    = 1'b1;
        stb.memOp = OP_BYTE;
        if (memAck) begin
          stb.byteDone = 1'b1;
          stateNxt     = flags.lastByte ? ST_STAT : ST_DATA;
        end
      end
      ST_STAT: begin
        memReq    = 1'b1;
        stb.memOp = OP_STAT;
        if (memAck) begin
          stb.descDone = 1'b1;
          rxDoneSet    = !flags.intSuppress;
          if (flags.frameComplete) begin
            stb.endOk   = 1'b1;
            dmaStartClr = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            stateNxt = ST_SCHK;
          end
        end
      end
      ST_FAIL: begin
        bufUnavailSet = 1'b1;
        stb.fail      = 1'b1;
        stateNxt      = ST_DROP;
      end
      ST_DROP: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.dropByte = 1'b1;
          if (flags.oneLeft) begin
            dmaStartClr = 1'b1;
            stateNxt    = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign frameActive = (state != ST_IDLE);

endmodule

// File: rtl/rx_ring_scatter_dp.sv
module rx_ring_scatter_dp
  import rx_ring_scatter_pkg::*;
#(
  parameter int MIN_BUF   = 64,
  parameter int FCS_BYTES = 4,
  parameter int LEN_W     = 14,
  parameter int BUF_W     = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ringLoad,
  input  logic [WORD_W-1:0] ringAddr,
  input  logic [7:0]        inData,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [WORD_W-1:0] memRdata,
  input  rxsStrobe_t        stb,
  output rxsFlag_t          flags,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [3:0]        memStrb,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] curDesc
);

  logic [WORD_W-1:0] headAddr, curAddr, startAddr, descAddr;
  logic [WORD_W-1:0] wStatus, wBuf, wNext;
  logic [BUF_W-1:0]  wSize;
  logic              wSup;
  logic [1:0]        wordIdx;
  logic [LEN_W-1:0]  bytesLeft, descBytes, offset;
  logic [LENF_W-1:0] lenField;
  logic              lastFlag, firstFlag;
  logic [7:0]        byteReg;

  // Fill plan for the descriptor just found, from its size and the bytes left
  logic [WORD_W-1:0] sizeW, leftW, lenCalc;
  logic              roomShort;
  logic [LEN_W-1:0]  bytesCalc;

  always_comb begin
    sizeW     = 32'(wSize);
    leftW     = 32'(bytesLeft);
    roomShort = sizeW < (leftW + 32'(FCS_BYTES));
    if (roomShort) begin
      bytesCalc = (sizeW < leftW) ? LEN_W'(wSize) : bytesLeft;
      lenCalc   = sizeW;
    end else begin
      bytesCalc = bytesLeft;
      lenCalc   = ((leftW < 32'(MIN_BUF)) ? 32'(MIN_BUF) : leftW) + 32'(FCS_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headAddr  <= '0;
      curAddr   <= '0;
      startAddr <= '0;
      descAddr  <= '0;
      wStatus   <= '0;
      wSize     <= '0;
      wSup      <= 1'b0;
      wBuf      <= '0;
      wNext     <= '0;
      wordIdx   <= '0;
      bytesLeft <= '0;
      descBytes <= '0;
      offset    <= '0;
      lenField  <= '0;
      lastFlag  <= 1'b0;
      firstFlag <= 1'b0;
      byteReg   <= '0;
    end else begin
      if (ringLoad) begin
        headAddr <= ringAddr;
        curAddr  <= ringAddr;
      end
      if (stb.ldFrame) begin
        bytesLeft <= inLen;
        firstFlag <= 1'b1;
        startAddr <= curAddr;
        descAddr  <= curAddr;
        wordIdx   <= '0;
      end
      if (stb.capWord) begin
        unique case (wordIdx)
          2'd0: wStatus <= memRdata;
          2'd1: begin
            wSize <= memRdata[BUF_W-1:0];
            wSup  <= memRdata[SUP_BIT];
          end
          2'd2: wBuf  <= memRdata;
          default: wNext <= memRdata;
        endcase
        wordIdx <= wordIdx + 2'd1;
      end
      if (stb.followNext) descAddr <= wNext;
      if (stb.setupFill) begin
        descBytes <= bytesCalc;
        lenField  <= lenCalc[LENF_W-1:0];
        lastFlag  <= !roomShort;
        offset    <= '0;
      end
      if (stb.takeByte) byteReg <= inData;
      if (stb.byteDone) offset <= offset + LEN_W'(1);
      if (stb.descDone) begin
        bytesLeft <= bytesLeft - descBytes;
        firstFlag <= 1'b0;
        startAddr <= wNext;
        descAddr  <= wNext;
      end
      if (stb.endOk) curAddr <= wNext;
      if (stb.fail) curAddr <= headAddr;
      if (stb.dropByte) bytesLeft <= bytesLeft - LEN_W'(1);
    end
  end

  always_comb begin
    flags.addrZero      = (descAddr == '0);
    flags.owned         = wStatus[OWN_BIT] && (32'(wSize) >= 32'(MIN_BUF));
    flags.nextIsStart   = (wNext == startAddr);
    flags.lastWord      = (wordIdx == 2'd3);
    flags.lastByte      = ((offset + LEN_W'(1)) == descBytes);
    flags.frameComplete = (bytesLeft == descBytes);
    flags.intSuppress   = wSup;
    flags.oneLeft       = (bytesLeft == LEN_W'(1));
  end

  logic [WORD_W-1:0] byteAddr, newStatus;

  always_comb begin
    byteAddr  = wBuf + 32'(offset);
    newStatus = (wStatus & ~OWN_MASK & ~LENF_MASK)
              | (32'(lenField) << LENF_LSB)
              | (32'(firstFlag) << FIRST_BIT)
              | (32'(lastFlag) << LAST_BIT);
    unique case (stb.memOp)
      OP_BYTE: begin
        memWe    = 1'b1;
        memAddr  = byteAddr;
        memStrb  = 4'b0001 << byteAddr[1:0];
        memWdata = {4{byteReg}};
      end
      OP_STAT: begin
        memWe    = 1'b1;
        memAddr  = descAddr;
        memStrb  = 4'hF;
        memWdata = newStatus;
      end
      default: begin
        memWe    = 1'b0;
        memAddr  = descAddr + {28'd0, wordIdx, 2'b00};
        memStrb  = 4'h0;
        memWdata = '0;
      end
    endcase
  end

  assign curDesc = curAddr;

endmodule

// File: rtl/rx_ring_scatter.sv
module rx_ring_scatter
  import rx_ring_scatter_pkg::*;
#(
  parameter int MIN_BUF   = 64,
  parameter int FCS_BYTES = 4,
  parameter int LEN_W     = 14,
  parameter int BUF_W     = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             ringLoad,
  input  logic [31:0]      ringAddr,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inData,
  input  logic [LEN_W-1:0] inLen,
  output logic             memReq,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [3:0]       memStrb,
  output logic [31:0]      memWdata,
  input  logic             memAck,
  input  logic [31:0]      memRdata,
  output logic             rxDoneSet,
  output logic             bufUnavailSet,
  output logic             dmaStartClr,
  output logic [31:0]      curDesc
);

  rxsStrobe_t stb;
  rxsFlag_t   flags;
  logic       frameActive;

  rx_ring_scatter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .inValid(inValid),
    .memAck(memAck), .flags(flags), .stb(stb), .memReq(memReq),
    .inReady(inReady), .rxDoneSet(rxDoneSet), .bufUnavailSet(bufUnavailSet),
    .dmaStartClr(dmaStartClr), .frameActive(frameActive)
  );

  rx_ring_scatter_dp #(
    .MIN_BUF(MIN_BUF), .FCS_BYTES(FCS_BYTES), .LEN_W(LEN_W), .BUF_W(BUF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ringLoad(ringLoad), .ringAddr(ringAddr),
    .inData(inData), .inLen(inLen), .memRdata(memRdata), .stb(stb),
    .flags(flags), .memWe(memWe), .memAddr(memAddr), .memStrb(memStrb),
    .memWdata(memWdata), .curDesc(curDesc)
  );

endmodule

// File: rtl/rx_ring_scatter_chk.sv
module rx_ring_scatter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxEnable,
  input logic        inReady,
  input logic        memReq,
  input logic        memAck,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic        rxDoneSet,
  input logic        bufUnavailSet,
  input logic        dmaStartClr,
  input logic        frameActive
);

  assert_refuse_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!frameActive && !rxEnable) |=> !frameActive);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> (!memReq && !inReady));

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_backpressure_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !inReady);

  assert_irq_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxDoneSet, bufUnavailSet}));

  assert_frame_end_R11: assert property (@(posedge clk) disable iff (!rstN)
    dmaStartClr |=> !frameActive);

endmodule

bind rx_ring_scatter rx_ring_scatter_chk u_chk (.*);

// File: tb/rx_ring_scatter_tb.sv
module rx_ring_scatter_tb;

  localparam int LEN_W = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0;
  logic ringLoad = 1'b0;
  logic [31:0] ringAddr = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inData = '0;
  logic [LEN_W-1:0] inLen = '0;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [3:0] memStrb;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic rxDoneSet, bufUnavailSet, dmaStartClr;
  logic [31:0] curDesc;

  always #5 clk = ~clk;

  rx_ring_scatter u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .ringLoad(ringLoad),
    .ringAddr(ringAddr), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLen(inLen), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memStrb(memStrb), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .rxDoneSet(rxDoneSet), .bufUnavailSet(bufUnavailSet),
    .dmaStartClr(dmaStartClr), .curDesc(curDesc)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Memory seen by the design and the reference model's shadow copy
  logic [7:0] mem [4096];
  logic [7:0] refMem [4096];

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic [31:0] data;
  } wr_t;
  wr_t expQ[$];

  function automatic logic [31:0] ref32(input int a);
    return {refMem[(a+3)&12'hfff], refMem[(a+2)&12'hfff], refMem[(a+1)&12'hfff], refMem[a&12'hfff]};
  endfunction

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  // Memory responder: one-cycle acknowledge, compares every write in order
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      int base;
      base = int'(memAddr & 32'h0000_0ffc);
      memAck <= 1'b1;
      if (memWe) begin
        for (int k = 0; k < 4; k++)
          if (memStrb[k]) mem[base + k] = memWdata[8*k +: 8];
        if (expQ.size() == 0) begin
          chk(1'b0, "R12 unexpected write", longint'(memAddr), 0);
        end else begin
          wr_t e;
          logic [31:0] m;
          e = expQ.pop_front();
          m = {{8{e.strb[3]}}, {8{e.strb[2]}}, {8{e.strb[1]}}, {8{e.strb[0]}}};
          chk(memAddr == e.addr && memStrb == e.strb, "R12 write address/lane",
              longint'({memStrb, memAddr}), longint'({e.strb, e.addr}));
          chk((memWdata & m) == (e.data & m), "R5 write data",
              longint'(memWdata & m), longint'(e.data & m));
        end
      end else begin
        memRdata <= {mem[base+3], mem[base+2], mem[base+1], mem[base]};
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  // Pulse and overlap monitors, sampled mid-cycle
  int doneTot = 0, uaTot = 0, clrTot = 0, overlapCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (rxDoneSet) doneTot++;
      if (bufUnavailSet) uaTot++;
      if (dmaStartClr) clrTot++;
      if (inReady && memReq) overlapCnt++;
    end
  end

  // Reference model state
  logic [31:0] mHead = '0, mCur = '0;
  int expDone, expUa;

  function automatic logic [31:0] findDesc(input logic [31:0] start);
    logic [31:0] a;
    a = start;
    for (int g = 0; g < 64; g++) begin
      if (a == 0) return 0;
      if (ref32(int'(a))[31] && (ref32(int'(a) + 4) & 32'h7ff) >= 64) return a;
      if (ref32(int'(a) + 12) == start) return 0;
      a = ref32(int'(a) + 12);
    end
    return 0;
  endfunction

  task automatic modelFrame(input int len, input int seed);
    logic [31:0] a, st, st2, bufA, nx, ns;
    int left, n, lf, idx, sz;
    bit first, last;
    expDone = 0; expUa = 0;
    left = len; first = 1; idx = 0;
    a = findDesc(mCur);
    if (a == 0) begin
      expUa++; mCur = mHead; return;
    end
    forever begin
      st = ref32(int'(a)); st2 = ref32(int'(a) + 4);
      bufA = ref32(int'(a) + 8); nx = ref32(int'(a) + 12);
      sz = int'(st2 & 32'h7ff);
      if (sz < left + 4) begin
        n = (sz < left) ? sz : left; lf = sz; last = 0;
      end else begin
        n = left; last = 1; lf = ((left < 64) ? 64 : left) + 4;
      end
      for (int k = 0; k < n; k++) begin
        logic [7:0] b;
        logic [31:0] ba;
        b = pay(seed, idx); idx++;
        ba = bufA + 32'(k);
        expQ.push_back('{ba, 4'b0001 << ba[1:0], {4{b}}});
        refMem[ba & 12'hfff] = b;
      end
      ns = (st & ~32'h8000_0000 & ~32'h3fff_0000) | (32'(lf) << 16) |
           (32'(first) << 9) | (32'(last) << 8);
      expQ.push_back('{a, 4'hF, ns});
      for (int k = 0; k < 4; k++) refMem[(int'(a) + k) & 12'hfff] = ns[8*k +: 8];
      if (!st2[31]) expDone++;
      left -= n; first = 0;
      if (left == 0) begin
        mCur = nx; break;
      end
      a = findDesc(nx);
      if (a == 0) begin
        expUa++; mCur = mHead; break;
      end
    end
  endtask

  task automatic setDesc(input int a, input bit own, input int size, input bit sup,
                         input int bufA, input int nx);
    logic [31:0] w [4];
    w[0] = (32'(own) << 31) | 32'h0000_0400;
    w[1] = (32'(sup) << 31) | 32'(size);
    w[2] = 32'(bufA);
    w[3] = 32'(nx);
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 4; k++) begin
        mem[a + 4*j + k] = w[j][8*k +: 8];
        refMem[a + 4*j + k] = w[j][8*k +: 8];
      end
  endtask

  task automatic loadRing(input logic [31:0] h);
    ringLoad = 1'b1; ringAddr = h;
    @(negedge clk);
    ringLoad = 1'b0;
    mHead = h; mCur = h;
  endtask

  task automatic sendBytes(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1; inData = pay(seed, i); inLen = LEN_W'(len);
      forever begin
        if (inReady) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    inValid = 1'b0;
  endtask

  task automatic runFrame(input int len, input int seed, input string tag);
    int sd, su, sc, g;
    modelFrame(len, seed);
    sd = doneTot; su = uaTot; sc = clrTot;
    sendBytes(len, seed);
    g = 0;
    while (clrTot == sc && g < 2000) begin
      @(negedge clk); g++;
    end
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5 all expected writes seen", expQ.size(), 0);
    expQ.delete();
    chk(doneTot - sd == expDone, "R9 receive-done pulses", doneTot - sd, expDone);
    chk(uaTot - su == expUa, {tag, " buffer-unavailable pulses"}, uaTot - su, expUa);
    chk(clrTot - sc == 1, "R11 dma-start clear pulses", clrTot - sc, 1);
    chk(curDesc == mCur, {tag, " current pointer"}, curDesc, mCur);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'h00; refMem[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk(curDesc == 0, "R11 reset pointer", curDesc, 0);
    chk(!inReady && !memReq, "R1 reset quiet", {inReady, memReq}, 0);
    chk(!rxDoneSet && !bufUnavailSet && !dmaStartClr, "R9 reset pulses",
        {rxDoneSet, bufUnavailSet, dmaStartClr}, 0);

    // Ring of three 100-byte buffers
    setDesc(32'h100, 1, 100, 0, 32'h400, 32'h110);
    setDesc(32'h110, 1, 100, 0, 32'h500, 32'h120);
    setDesc(32'h120, 1, 100, 0, 32'h600, 32'h100);
    loadRing(32'h100);

    // R1: disabled receiver refuses a waiting frame
    begin
      int bad;
      bad = 0;
      inValid = 1'b1; inData = 8'h55; inLen = LEN_W'(10);
      repeat (20) begin
        @(negedge clk);
        if (inReady || memReq) bad++;
      end
      inValid = 1'b0;
      chk(bad == 0, "R1 refused while disabled", bad, 0);
      chk(curDesc == 32'h100, "R1 pointer untouched", curDesc, 32'h100);
    end
    rxEnable = 1'b1;
    @(negedge clk);

    runFrame(30, 3, "R7");    // short frame, padded length 68, first+last
    runFrame(150, 9, "R6");   // 100-byte partial fill, then last descriptor
    runFrame(20, 5, "R4");    // ring exhausted: whole frame dropped, pointer to head

    // Small buffer skipped, suppressed interrupt, four-byte margin cases
    setDesc(32'h100, 1, 63, 0, 32'h400, 32'h110);
    setDesc(32'h110, 1, 100, 1, 32'h500, 32'h120);
    setDesc(32'h120, 1, 100, 0, 32'h600, 32'h100);
    loadRing(32'h100);
    runFrame(96, 17, "R2");   // skips 63-byte buffer, exact fit with margin
    runFrame(97, 21, "R8");   // fits the buffer but not the margin

    // Chain ends in a zero next address after a partial fill
    setDesc(32'h100, 1, 80, 0, 32'h400, 32'h110);
    setDesc(32'h110, 0, 100, 0, 32'h500, 32'h000);
    loadRing(32'h100);
    runFrame(120, 33, "R10");

    // Zero head address fails at once
    loadRing(32'h0);
    runFrame(5, 2, "R3");

    // Single self-linked descriptor, long frame without padding
    setDesc(32'h100, 1, 200, 0, 32'h400, 32'h100);
    loadRing(32'h100);
    runFrame(80, 40, "R7");

    chk(overlapCnt == 0, "R12 stream ready during memory access", overlapCnt, 0);
    finishRun();
  end

endmodule